// File: doc/BRIEF.md
# Signed Number Format Converter

This block translates a small signed word from one of three signed encodings into another: sign-magnitude, ones complement and twos complement. Two select inputs name the source encoding and the target encoding. The block returns the converted word and a flag. The flag rises when the value cannot be written in the target encoding. The block has no clock and no storage, so a new result is ready once the inputs have settled through the logic.

Sign-magnitude and ones complement each have two ways to write zero. Twos complement has only one. The converter preserves the negative-zero distinction between the two redundant encodings, and folds both negative zeros into plain zero when the target is twos complement. The most negative twos complement value has no counterpart in the redundant encodings. For that value the converter raises the flag and drives an all-zero word. If the two selects are equal, or either select holds the reserved code, the input word is passed through unchanged.

Top module: `signed_fmt_conv`

## Requirements
- R1: Select encoding is 2'b00 sign-magnitude, 2'b01 ones complement, 2'b10 twos complement, and 2'b11 reserved. With source 00 and target 10, every sign-magnitude word converts to the twos complement word of the same value.
- R2: With source 00 and target 01, every sign-magnitude word other than 1000 converts to the ones complement word of the same value.
- R3: With source 01 and target 10, every ones complement word other than 1111 converts to the twos complement word of the same value.
- R4: With source 01 and target 00, every ones complement word converts to the sign-magnitude word of the same value, and ones complement 1111 gives sign-magnitude 1000.
- R5: With source 10 and target 00 or 01, every twos complement word except 1000 converts to the target word of the same value. Twos complement zero gives positive zero 0000.
- R6: Sign-magnitude 1000 and ones complement 1111 both convert to twos complement 0000.
- R7: Twos complement 1000 (minus eight) with target 00 or 01 drives the unrepresentable flag high and the data output to 0000.
- R8: The unrepresentable flag is low for every other combination of data and selects.
- R9: When the source and target selects are equal, the data output equals the data input.
- R10: When either select is 2'b11, the data output equals the data input and the flag is low.
- R11: Sign-magnitude 1000 converted to ones complement gives 1111. This keeps negative zero negative between the two redundant encodings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 4 | Word in the source encoding |
| in_fmt | input | 2 | Source encoding select |
| out_fmt | input | 2 | Target encoding select |
| data_out | output | 4 | Word in the target encoding |
| unrep_flag | output | 1 | High when the value has no target encoding |

## Verification
Two functions can apply to the same input combination: passthrough and the unrepresentable check. This happens when the word is 1000 with source twos complement and a target of twos complement or the reserved code. In that case passthrough must win: the data comes out unchanged and the flag stays low. The exhaustive sweep applies every data word under all sixteen select pairs, so these overlaps occur alongside the real conversions. The scoreboard judges each case against a model that works in plain signed integers, so the two functions are never traced back to the same source in the logic. Negative zero is a second overlap. It is both a zero and a negative word, and the sweep checks it into each of the three targets.

// File: rtl/snc_pkg.sv
package snc_pkg;

  typedef enum logic [1:0] {
    FMT_SM  = 2'b00,
    FMT_OC  = 2'b01,
    FMT_TC  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

endpackage

// File: rtl/snc_decode.sv
module snc_decode
  import snc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] code,
  input  fmt_e         fmt,
  output logic         sign,
  output logic [W-1:0] mag,
  output logic         neg_zero
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] tc_abs(input logic [W-1:0] c);
    return c[W-1] ? ((~c) + ONE) : c;
  endfunction

  function automatic logic [W-1:0] oc_abs(input logic [W-1:0] c);
    return c[W-1] ? {1'b0, ~c[W-2:0]} : {1'b0, c[W-2:0]};
  endfunction

  always_comb begin
    sign = code[W-1];
    unique case (fmt)
      FMT_SM:  mag = {1'b0, code[W-2:0]};
      FMT_OC:  mag = oc_abs(code);
      FMT_TC:  mag = tc_abs(code);
      default: begin
        sign = 1'b0;
        mag  = '0;
      end
    endcase
    neg_zero = sign && (mag == '0);
  end

endmodule

// File: rtl/snc_encode.sv
module snc_encode
  import snc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         sign,
  input  logic [W-1:0] mag,
  input  fmt_e         fmt,
  output logic [W-1:0] code,
  output logic         unrep
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] to_tc(input logic s, input logic [W-1:0] m);
    return s ? ((~m) + ONE) : m;
  endfunction

  function automatic logic [W-1:0] to_oc(input logic s, input logic [W-2:0] m);
    return s ? ~{1'b0, m} : {1'b0, m};
  endfunction

  logic over_range;

  always_comb begin
    over_range = mag[W-1];
    unrep      = 1'b0;
    unique case (fmt)
      FMT_SM: begin
        unrep = over_range;
        code  = over_range ? '0 : {sign, mag[W-2:0]};
      end
      FMT_OC: begin
        unrep = over_range;
        code  = over_range ? '0 : to_oc(sign, mag[W-2:0]);
      end
      FMT_TC:  code = to_tc(sign, mag);
      default: code = '0;
    endcase
  end

endmodule

// File: rtl/signed_fmt_conv.sv
module signed_fmt_conv
  import snc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] data_in,
  input  logic [1:0]   in_fmt,
  input  logic [1:0]   out_fmt,
  output logic [W-1:0] data_out,
  output logic         unrep_flag
);

  fmt_e         src_fmt;
  fmt_e         dst_fmt;
  logic         dec_sign;
  logic [W-1:0] dec_mag;
  logic         dec_neg_zero;
  logic [W-1:0] enc_code;
  logic         enc_unrep;
  logic         bypass;

  assign src_fmt = fmt_e'(in_fmt);
  assign dst_fmt = fmt_e'(out_fmt);

  snc_decode #(.W(W)) u_dec (
    .code     (data_in),
    .fmt      (src_fmt),
    .sign     (dec_sign),
    .mag      (dec_mag),
    .neg_zero (dec_neg_zero)
  );

  snc_encode #(.W(W)) u_enc (
    .sign  (dec_sign),
    .mag   (dec_mag),
    .fmt   (dst_fmt),
    .code  (enc_code),
    .unrep (enc_unrep)
  );

  assign bypass     = (src_fmt == dst_fmt) || (src_fmt == FMT_RSV) || (dst_fmt == FMT_RSV);
  assign data_out   = bypass ? data_in : enc_code;
  assign unrep_flag = !bypass && enc_unrep;

endmodule

// File: rtl/snc_checker.sv
module snc_checker #(
  parameter int W = 4
) (
  input logic [W-1:0] data_in,
  input logic [1:0]   in_fmt,
  input logic [1:0]   out_fmt,
  input logic [W-1:0] data_out,
  input logic         unrep_flag,
  input logic         neg_zero
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = '1;

  logic tc_min_to_redundant;
  logic neg_zero_to_tc;

  assign tc_min_to_redundant = (in_fmt == 2'b10) && (data_in == MOST_NEG) &&
                               ((out_fmt == 2'b00) || (out_fmt == 2'b01));
  assign neg_zero_to_tc = (out_fmt == 2'b10) &&
                          (((in_fmt == 2'b00) && (data_in == MOST_NEG)) ||
                           ((in_fmt == 2'b01) && (data_in == ALL_ONES)));

  always_comb begin
    AST_UNREP_DATA_ZERO: assert (!tc_min_to_redundant || (unrep_flag && data_out == '0)); // R7
    AST_FLAG_ONLY_TC_MIN: assert (!unrep_flag || tc_min_to_redundant); // R8
    AST_SAME_FMT_PASS: assert (in_fmt != out_fmt || data_out == data_in); // R9
    AST_RSV_PASS: assert (!(in_fmt == 2'b11 || out_fmt == 2'b11) || (data_out == data_in && !unrep_flag)); // R10
    AST_NEG_ZERO_TO_TC: assert (!neg_zero_to_tc || (data_out == '0 && neg_zero)); // R6
  end

endmodule

bind signed_fmt_conv snc_checker #(.W(W)) u_chk (
  .data_in    (data_in),
  .in_fmt     (in_fmt),
  .out_fmt    (out_fmt),
  .data_out   (data_out),
  .unrep_flag (unrep_flag),
  .neg_zero   (dec_neg_zero)
);

// File: tb/test_signed_fmt_conv.sv
module test_signed_fmt_conv;

  typedef struct {
    logic [3:0] din;
    logic [1:0] fi;
    logic [1:0] fo;
    logic [3:0] exp_data;
    logic       exp_flag;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] data_in = '0;
  logic [1:0] in_fmt = '0;
  logic [1:0] out_fmt = '0;
  logic [3:0] data_out;
  logic       unrep_flag;

  int    checks = 0;
  int    errors = 0;
  bit    driving_done = 1'b0;
  bit    finished = 1'b0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  signed_fmt_conv i_signed_fmt_conv (
    .data_in    (data_in),
    .in_fmt     (in_fmt),
    .out_fmt    (out_fmt),
    .data_out   (data_out),
    .unrep_flag (unrep_flag)
  );

  // Reference model working in plain integers
  function automatic int value_of(input logic [3:0] d, input logic [1:0] f, output bit neg);
    int m;
    neg = d[3];
    case (f)
      2'b00: m = int'(d[2:0]);
      2'b01: m = d[3] ? int'(3'(~d[2:0])) : int'(d[2:0]);
      default: m = d[3] ? (16 - int'(d)) : int'(d);
    endcase
    return neg ? -m : m;
  endfunction

  task automatic model(input logic [3:0] d, input logic [1:0] fi, input logic [1:0] fo,
                       output logic [3:0] q, output logic fl, output string tag);
    bit neg;
    int v;
    int a;
    fl = 1'b0;
    if (fi == 2'b11 || fo == 2'b11) begin q = d; tag = "R10"; return; end
    if (fi == fo) begin q = d; tag = "R9"; return; end
    v = value_of(d, fi, neg);
    a = (v < 0) ? -v : v;
    case (fo)
      2'b10: q = 4'(v);
      2'b00: q = (a > 7) ? 4'b0000 : {neg, 3'(a)};
      default: q = (a > 7) ? 4'b0000 : (neg ? ~{1'b0, 3'(a)} : {1'b0, 3'(a)});
    endcase
    if (a > 7) fl = 1'b1;
    if (fl) tag = "R7";
    else if (neg && v == 0 && fo == 2'b10) tag = "R6";
    else if (neg && v == 0 && fi == 2'b00) tag = "R11";
    else if (fi == 2'b00) tag = (fo == 2'b10) ? "R1" : "R2";
    else if (fi == 2'b01) tag = (fo == 2'b10) ? "R3" : "R4";
    else tag = "R5";
  endtask

  // Driver: applies a stimulus and pushes its expectation
  task automatic drive(input logic [3:0] d, input logic [1:0] fi, input logic [1:0] fo);
    item_t it;
    @(posedge clk);
    #1;
    data_in = d;
    in_fmt  = fi;
    out_fmt = fo;
    it.din = d;
    it.fi  = fi;
    it.fo  = fo;
    model(d, fi, fo, it.exp_data, it.exp_flag, it.tag);
    sb_q.push_back(it);
  endtask

  // Monitor: compares mid-cycle, away from the driving edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (data_out !== it.exp_data) begin
          errors++;
          $display("FAIL %s data in=%b fi=%b fo=%b actual=%b expected=%b",
                   it.tag, it.din, it.fi, it.fo, data_out, it.exp_data);
        end
        checks++;
        if (unrep_flag !== it.exp_flag) begin
          errors++;
          $display("FAIL %s flag in=%b fi=%b fo=%b actual=%b expected=%b",
                   it.exp_flag ? "R7" : "R8", it.din, it.fi, it.fo, unrep_flag, it.exp_flag);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // first item: initial quiet state, sign-magnitude passthrough of zero (R9)
    drive(4'b0000, 2'b00, 2'b00);
    // named corner cases up front: R6, R7, R11, R4 negative zero
    drive(4'b1000, 2'b00, 2'b10);
    drive(4'b1111, 2'b01, 2'b10);
    drive(4'b1000, 2'b10, 2'b00);
    drive(4'b1000, 2'b10, 2'b01);
    drive(4'b1000, 2'b00, 2'b01);
    drive(4'b1111, 2'b01, 2'b00);
    drive(4'b1000, 2'b10, 2'b10);
    drive(4'b1000, 2'b10, 2'b11);
    // exhaustive sweep of every word under every select pair
    for (int fi = 0; fi < 4; fi++)
      for (int fo = 0; fo < 4; fo++)
        for (int d = 0; d < 16; d++)
          drive(4'(d), 2'(fi), 2'(fo));
    repeat (3) @(posedge clk);
    driving_done = 1'b1;
  end

  initial begin
    wait (driving_done);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the sweep ended");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule